// File: doc/BRIEF.md
# I2C Master Controller with Coded Error Reporting

This block is a single-master I2C controller. A one-cycle start pulse launches one transaction, chosen by the byte counts and a read-type input. The transaction is a multi-byte write, a random read (write phase, repeated START, read phase), or a current-address read that has no write phase. Write bytes arrive on a flat packed bus together with a byte count. Read bytes leave on a flat packed bus, and a second count sets how many are read. Both lines are open-drain: the block only pulls SCL or SDA low or lets it go, and it reads the real line levels back through two inputs.

Each transaction ends with a one-cycle done pulse, successful or not. A 3-bit code states how it ended: missing acknowledge, lost arbitration, timeout, or a bus that was already held low when the transaction was requested. The SCL rate comes from a compile-time divider, and a compile-time limit bounds the length of any transaction. Clock stretching, 10-bit addressing and retry after losing arbitration are not supported.

Top module: `i2c_err_master`

## Requirements
- R1: After reset, busy, done and error are low, err_code is 0, rd_data is all zero and neither scl_low nor sda_low is asserted. Both lines stay released whenever busy is low.
- R2: A start pulse taken while idle with both lines high raises busy from the next cycle until the transaction ends. At the end, done is high for exactly one cycle and busy falls in that same cycle. The error output is high exactly when err_code is nonzero. err_code codes: 0 ok, 1 no acknowledge, 2 arbitration lost, 3 timeout, 4 bus occupied.
- R3: If scl_in or sda_in is low when start is pulsed in idle, the request is refused. done and code 4 appear in the next cycle, busy never rises, and no line is driven.
- R4: When rd_len is 0, the transaction is a plain write, whatever rd_random is. It sends START, then bytes in ascending order from wr_data[7:0] (byte 0 is the address byte), then STOP. Each byte is sent MSB first and is followed by an acknowledge slot. A wr_len of 0 counts as 1, and values above WR_MAX are capped at WR_MAX.
- R5: When rd_random is 1 and rd_len is nonzero, the master first writes wr_len bytes. It then sends a repeated START, then byte 0 with bit 0 forced to 1, then reads rd_len bytes (capped at RD_MAX), then STOP.
- R6: When rd_random is 0 and rd_len is nonzero, the master sends START, then byte 0 with bit 0 forced to 1, then reads rd_len bytes, then STOP.
- R7: Read byte k is stored at rd_data[8k+7:8k], and rd_data is cleared when a transaction is taken. The master acknowledges every read byte except the last, which it leaves unacknowledged before STOP.
- R8: When no acknowledge follows any byte the master sent, the master issues STOP and ends with code 1.
- R9: When the master releases SDA for a data bit and samples it low at the end of SCL high, it releases both lines at once. It ends with code 2 and sends no STOP.
- R10: A transaction still running after TMO_CYCLES cycles of busy is aborted. busy is then high for exactly TMO_CYCLES cycles, both lines are released, and the code is 3.
- R11: Every SCL high phase of a bit lasts PHASE_DIV+1 clock cycles. The repeated-START high lasts twice that. SDA changes while SCL is high only to form START and STOP, so each transaction shows one START per segment and one STOP unless it ended with code 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_random | input | 1 | 1: random read, 0: current-address read |
| wr_len | input | 8 | Number of bytes in the write phase |
| wr_data | input | WR_MAX*8 | Write bytes, byte 0 in bits [7:0] |
| rd_len | input | 8 | Number of bytes to read; 0 selects a plain write |
| rd_data | output | RD_MAX*8 | Received bytes, first in bits [7:0] |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_low | output | 1 | Pull SCL low when high, release when low |
| sda_low | output | 1 | Pull SDA low when high, release when low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | High when err_code is nonzero |
| err_code | output | 3 | Outcome of the last transaction |

## Verification
A wrong bit counter or a wrong segment state corrupts the byte framing, and it shows up at the ports within one byte time. The device then sees a shifted address and withholds its acknowledge, so the code turns to 1 and rd_data differs in the first affected byte. A phase counter that is off changes the width of SCL high pulses on the very next bit. A wrong decision about the end of a transfer shows as a missing or extra STOP on the line, or as busy lasting a different number of cycles than the timeout limit demands.

// File: rtl/i2c_err_master.sv
module i2c_err_master #(
  parameter int WR_MAX     = 8,
  parameter int RD_MAX     = 8,
  parameter int PHASE_DIV  = 499,
  parameter int TMO_CYCLES = 100000000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  rd_random,
  input  logic [7:0]            wr_len,
  input  logic [WR_MAX*8-1:0]   wr_data,
  input  logic [7:0]            rd_len,
  output logic [RD_MAX*8-1:0]   rd_data,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  scl_low,
  output logic                  sda_low,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [2:0]            err_code
);
  localparam int WB = WR_MAX * 8;
  localparam int RB = RD_MAX * 8;
  localparam int DW = $clog2(PHASE_DIV + 1);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [7:0] WMAX8 = 8'(WR_MAX);
  localparam logic [7:0] RMAX8 = 8'(RD_MAX);

  typedef enum logic [3:0] {IDLE, STA, BLO, BHI, RSA, RSB, SPA, SPB, SPC} st_t;
  typedef enum logic [1:0] {SG_W, SG_A, SG_R} seg_t;

  st_t             st;
  seg_t            seg;
  logic [DW-1:0]   dcnt;
  logic [TW-1:0]   tcnt;
  logic [3:0]      bitn;
  logic [7:0]      idx, wn, rn, sh;
  logic [WB-1:0]   wq, wsel;

  wire       tick   = dcnt == DW'(PHASE_DIV);
  wire       rxb    = seg == SG_R;
  wire [7:0] nidx   = idx + 8'd1;
  wire       last_r = nidx == rn;
  wire       last_w = nidx == wn;
  wire       rd_now = rd_len != 8'd0 && !rd_random;

  assign wsel  = wq >> {nidx, 3'b000};
  assign error = err_code != 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; seg <= SG_W; dcnt <= '0; tcnt <= '0; bitn <= '0;
      idx <= '0; wn <= '0; rn <= '0; sh <= '0; wq <= '0;
      rd_data <= '0; scl_low <= 1'b0; sda_low <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err_code <= 3'd0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          if (!scl_in || !sda_in) begin
            done <= 1'b1;
            err_code <= 3'd4;
          end else begin
            busy <= 1'b1; err_code <= 3'd0; rd_data <= '0;
            wq <= wr_data;
            wn <= (wr_len == 8'd0) ? 8'd1 : ((wr_len > WMAX8) ? WMAX8 : wr_len);
            rn <= (rd_len > RMAX8) ? RMAX8 : rd_len;
            seg <= rd_now ? SG_A : SG_W;
            sh <= rd_now ? {wr_data[7:1], 1'b1} : wr_data[7:0];
            idx <= '0; bitn <= '0; dcnt <= '0; tcnt <= '0;
            sda_low <= 1'b1;
            st <= STA;
          end
        end
      end else if (tcnt == TW'(TMO_CYCLES - 1)) begin
        scl_low <= 1'b0; sda_low <= 1'b0; busy <= 1'b0; done <= 1'b1;
        err_code <= 3'd3; st <= IDLE;
      end else begin
        tcnt <= tcnt + TW'(1);
        dcnt <= tick ? '0 : dcnt + DW'(1);
        case (st)
          STA: if (tick) begin scl_low <= 1'b1; st <= BLO; end
          BLO: begin
            if (dcnt == '0)
              sda_low <= (bitn == 4'd8) ? (rxb && !last_r) : (!rxb && !sh[7]);
            if (tick) begin scl_low <= 1'b0; st <= BHI; end
          end
          BHI: if (tick) begin
            if (bitn != 4'd8) begin
              if (!rxb && !sda_low && !sda_in) begin
                scl_low <= 1'b0; sda_low <= 1'b0; busy <= 1'b0; done <= 1'b1;
                err_code <= 3'd2; st <= IDLE;
              end else begin
                sh <= {sh[6:0], rxb ? sda_in : 1'b0};
                bitn <= bitn + 4'd1;
                scl_low <= 1'b1;
                st <= BLO;
              end
            end else begin
              scl_low <= 1'b1;
              bitn <= '0;
              if (rxb) begin
                rd_data <= rd_data | (RB'(sh) << {idx, 3'b000});
                if (last_r) st <= SPA;
                else begin idx <= nidx; st <= BLO; end
              end else if (sda_in) begin
                err_code <= 3'd1; st <= SPA;
              end else if (seg == SG_A) begin
                seg <= SG_R; idx <= '0; st <= BLO;
              end else if (!last_w) begin
                idx <= nidx; sh <= wsel[7:0]; st <= BLO;
              end else if (rn != 8'd0) begin
                seg <= SG_A; sh <= {wq[7:1], 1'b1}; st <= RSA;
              end else begin
                st <= SPA;
              end
            end
          end
          RSA: begin
            if (dcnt == '0) sda_low <= 1'b0;
            if (tick) begin scl_low <= 1'b0; st <= RSB; end
          end
          RSB: if (tick) begin sda_low <= 1'b1; st <= STA; end
          SPA: begin
            if (dcnt == '0) sda_low <= 1'b1;
            if (tick) begin scl_low <= 1'b0; st <= SPB; end
          end
          SPB: if (tick) begin sda_low <= 1'b0; st <= SPC; end
          SPC: if (tick) begin busy <= 1'b0; done <= 1'b1; st <= IDLE; end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_end_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_refuse_busy_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start && (!scl_in || !sda_in)) |=> (done && !busy && err_code == 3'd4));

  assert_nack_goes_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BHI && tick && bitn == 4'd8 && !rxb && sda_in && tcnt != TW'(TMO_CYCLES - 1))
      |=> (st == SPA && err_code == 3'd1));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd2) |-> (!scl_low && !sda_low));

  assert_sda_hold_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BHI && $past(st) == BHI) |-> $stable(sda_low));
endmodule

// File: tb/i2c_err_master_test.sv
module i2c_err_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int P_DIV      = 3;
  localparam int PH         = P_DIV + 1;
  localparam int TMO_LONG   = 4000;
  localparam int TMO_SHORT  = 150;
  localparam int NV         = 13;

  // {rd_random, wr_len, rd_len, wr_data, expected rd_data, expected code}
  localparam logic [147:0] VEC [NV] = '{
    {1'b0, 8'd4, 8'd0, 64'h00000000_221102A0, 64'h0, 3'd0},
    {1'b1, 8'd2, 8'd2, 64'h02A0, 64'h2211, 3'd0},
    {1'b0, 8'd1, 8'd1, 64'hA0, 64'h34, 3'd0},
    {1'b0, 8'd2, 8'd0, 64'h55A2, 64'h0, 3'd1},
    {1'b0, 8'd4, 8'd0, 64'h77EE06A0, 64'h0, 3'd1},
    {1'b1, 8'd2, 8'd9, 64'h00A0, 64'h37363534_22113130, 3'd0},
    {1'b0, 8'd0, 8'd0, 64'hA0, 64'h0, 3'd0},
    {1'b0, 8'd1, 8'd3, 64'hA0, 64'h3A3938, 3'd0},
    {1'b0, 8'd1, 8'd1, 64'hA2, 64'h0, 3'd1},
    {1'b1, 8'd3, 8'd0, 64'h5A0AA0, 64'h0, 3'd0},
    {1'b1, 8'd2, 8'd1, 64'h0AA0, 64'h5A, 3'd0},
    {1'b0, 8'd9, 8'd0, 64'h06050403_02010CA0, 64'h0, 3'd0},
    {1'b1, 8'd2, 8'd4, 64'h0CA0, 64'h04030201, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd_random = 1'b0;
  logic [7:0] wr_len = '0, rd_len = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic m_scl_low, m_sda_low, busy, done, error;
  logic [2:0] err_code;
  logic s_sda_low, hold_scl = 1'b0, hold_sda = 1'b0;
  logic scl_ln, sda_ln;

  logic t_start = 1'b0, t_hold = 1'b0;
  logic [63:0] t_rd;
  logic t_scl_low, t_sda_low, t_busy, t_done, t_error;
  logic [2:0] t_code;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_ln = !m_scl_low && !hold_scl;
  assign sda_ln = !m_sda_low && !s_sda_low && !hold_sda;

  i2c_err_master #(.WR_MAX(8), .RD_MAX(8), .PHASE_DIV(P_DIV), .TMO_CYCLES(TMO_LONG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_random(rd_random), .wr_len(wr_len),
    .wr_data(wr_data), .rd_len(rd_len), .rd_data(rd_data), .scl_in(scl_ln), .sda_in(sda_ln),
    .scl_low(m_scl_low), .sda_low(m_sda_low), .busy(busy), .done(done), .error(error),
    .err_code(err_code));

  i2c_err_master #(.WR_MAX(8), .RD_MAX(8), .PHASE_DIV(P_DIV), .TMO_CYCLES(TMO_SHORT)) uut_to (
    .clk(clk), .rst_n(rst_n), .start(t_start), .rd_random(1'b0), .wr_len(8'd8),
    .wr_data(64'h0), .rd_len(8'd0), .rd_data(t_rd), .scl_in(!t_scl_low),
    .sda_in(!t_sda_low && !t_hold), .scl_low(t_scl_low), .sda_low(t_sda_low),
    .busy(t_busy), .done(t_done), .error(t_error), .err_code(t_code));

  // device model at address 0x50: first written byte sets a pointer, later ones store
  logic scl_p, sda_p, act, rw, tx, in_ack, is_addr, first_data, mack;
  logic [7:0] sh, txb;
  logic [3:0] ptr;
  logic [7:0] mem [16];
  int bitn, nstart, nstop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1; sda_p <= 1'b1; act <= 1'b0; rw <= 1'b0; tx <= 1'b0; in_ack <= 1'b0;
      is_addr <= 1'b0; first_data <= 1'b0; mack <= 1'b0; sh <= '0; txb <= '0; ptr <= '0;
      bitn <= 0; nstart <= 0; nstop <= 0; s_sda_low <= 1'b0;
      for (int i = 0; i < 16; i++) mem[i] <= 8'h30 + 8'(i);
    end else begin
      scl_p <= scl_ln; sda_p <= sda_ln;
      if (scl_p && scl_ln && sda_p && !sda_ln) begin
        nstart <= nstart + 1; act <= 1'b1; is_addr <= 1'b1; bitn <= 0; in_ack <= 1'b0;
        tx <= 1'b0; s_sda_low <= 1'b0; first_data <= 1'b1;
      end else if (scl_p && scl_ln && !sda_p && sda_ln) begin
        nstop <= nstop + 1; act <= 1'b0; s_sda_low <= 1'b0;
      end else if (act) begin
        if (!scl_p && scl_ln) begin
          if (in_ack) begin bitn <= 9; mack <= !sda_ln; end
          else begin sh <= {sh[6:0], sda_ln}; bitn <= bitn + 1; end
        end else if (scl_p && !scl_ln) begin
          if (bitn == 8 && !in_ack) begin
            in_ack <= 1'b1;
            if (tx) s_sda_low <= 1'b0;
            else if (is_addr) begin
              if (sh[7:1] == 7'h50) begin s_sda_low <= 1'b1; rw <= sh[0]; end
              else act <= 1'b0;
            end else if (sh == 8'hEE) act <= 1'b0;
            else begin
              s_sda_low <= 1'b1; first_data <= 1'b0;
              if (first_data) ptr <= sh[3:0];
              else begin mem[ptr] <= sh; ptr <= ptr + 4'd1; end
            end
          end else if (in_ack) begin
            in_ack <= 1'b0; bitn <= 0; s_sda_low <= 1'b0; is_addr <= 1'b0;
            if ((is_addr && rw) || (tx && mack)) begin
              tx <= 1'b1; txb <= mem[ptr]; ptr <= ptr + 4'd1; s_sda_low <= !mem[ptr][7];
            end else if (tx) act <= 1'b0;
          end else if (tx && bitn >= 1 && bitn <= 7) begin
            s_sda_low <= !txb[7 - bitn];
          end
        end
      end
    end
  end

  // SCL high-pulse width monitor (pulses that begin with a rise during a transaction)
  int hcnt = 0, bad_w = 0, good_w = 0;
  logic seen_rise = 1'b0, scl_prev = 1'b1;
  always @(negedge clk) begin
    if (!busy) begin seen_rise = 1'b0; hcnt = 0; end
    else if (scl_ln) begin
      if (!scl_prev) begin seen_rise = 1'b1; hcnt = 0; end
      hcnt++;
    end else if (scl_prev && seen_rise) begin
      if (hcnt == PH || hcnt == 2 * PH) good_w++; else bad_w++;
      seen_rise = 1'b0;
    end
    scl_prev = scl_ln;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<=150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic run_vec(input logic [147:0] v);
    logic mode; logic [7:0] wl, rl; logic [63:0] wd, erd; logic [2:0] ec;
    int s0, p0, bw0, gw0, es; string rq;
    {mode, wl, rl, wd, erd, ec} = v;
    @(negedge clk);
    rd_random = mode; wr_len = wl; rd_len = rl; wr_data = wd;
    s0 = nstart; p0 = nstop; bw0 = bad_w; gw0 = good_w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    while (!done) @(negedge clk);
    rq = (rl == 8'd0) ? "R4 write" : (mode ? "R5 random read" : "R6 current read");
    chk(err_code == ec, (ec == 3'd1) ? "R8 no-ack code" : rq, 64'(err_code), 64'(ec));
    chk(error == (ec != 3'd0), "R2 error flag", 64'(error), 64'(ec != 3'd0));
    chk(busy == 1'b0, "R2 busy ends with done", 64'(busy), 64'd0);
    chk(rd_data == erd, "R7 read data", rd_data, erd);
    es = (mode && rl != 8'd0 && ec == 3'd0) ? 2 : 1;
    @(negedge clk);
    chk(done == 1'b0, "R2 done single cycle", 64'(done), 64'd0);
    chk(nstart - s0 == es, "R11 START count", 64'(nstart - s0), 64'(es));
    chk(nstop - p0 == 1, "R11 STOP count", 64'(nstop - p0), 64'd1);
    chk(bad_w == bw0 && good_w > gw0, "R11 SCL high width", 64'(bad_w - bw0), 64'd0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && err_code == 3'd0, "R1 reset status", 64'({busy, done, error, err_code}), 64'h0);
    chk(!m_scl_low && !m_sda_low && rd_data == 64'h0, "R1 reset lines", rd_data, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R3: bus held low at request time
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      hold_scl = (k == 0); hold_sda = (k == 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && err_code == 3'd4 && error, "R3 refused code", 64'(err_code), 64'd4);
      chk(!busy && !m_scl_low && !m_sda_low, "R3 nothing driven", 64'({busy, m_scl_low, m_sda_low}), 64'h0);
      @(negedge clk);
      hold_scl = 1'b0; hold_sda = 1'b0;
      repeat (2 * PH) @(negedge clk);
    end

    // R9: another device pulls SDA low while the master sends a 1 bit
    rd_random = 1'b0; wr_len = 8'd1; rd_len = 8'd0; wr_data = 64'hA0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (scl_ln) @(negedge clk);
    hold_sda = 1'b1;
    while (!done) @(negedge clk);
    chk(err_code == 3'd2 && !busy, "R9 arbitration code", 64'(err_code), 64'd2);
    chk(!m_scl_low && !m_sda_low, "R9 lines released", 64'({m_scl_low, m_sda_low}), 64'h0);
    n = 0;
    for (int k = 0; k < 3 * PH; k++) begin
      @(negedge clk);
      if (m_scl_low || m_sda_low) n++;
    end
    chk(n == 0, "R9 no STOP after loss", 64'(n), 64'd0);
    hold_sda = 1'b0;

    // R10: timeout on the second instance
    @(negedge clk);
    t_start = 1'b1;
    @(negedge clk);
    t_start = 1'b0; t_hold = 1'b1;
    n = 0;
    while (!t_done) begin
      if (t_busy) n++;
      @(negedge clk);
    end
    chk(n == TMO_SHORT, "R10 busy length", 64'(n), 64'(TMO_SHORT));
    chk(t_code == 3'd3 && t_error && !t_busy, "R10 timeout code", 64'(t_code), 64'd3);
    chk(!t_scl_low && !t_sda_low, "R10 lines released", 64'({t_scl_low, t_sda_low}), 64'h0);
    t_hold = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule